// File: doc/BRIEF.md
# Multi-target SPI chip-select controller

This block sits beside the shift engine of a serial master and owns its three active-low chip-select lines. Each command begins with a one-cycle start strobe. In that cycle the block captures a control word. The word picks the target device, says whether the select line is locked across command boundaries and whether it is released when the command ends, says whether a data phase occurs and in which direction, and gives the number of data lanes. The shift engine signals the end of a command with a done strobe and reports each moved byte with a tick.

A lock keeps the chosen line asserted after its command ends, so several commands can run as one device transaction. Later commands keep the line held until a command with its release bit set completes. When a new command names another device while a line is held, the block puts a gap of at least one clock between dropping the old line and asserting the new one. A byte counter loaded from the command tracks the data phase and pulses once when the programmed byte count has been moved.

Top module: `spi_cs_ctrl`

## Requirements
- R1: Target select code `tgt_sel` 2'b00 drives only `cs_n[0]` low, 2'b01 only `cs_n[1]`, 2'b10 only `cs_n[2]`. The other lines stay high. The line asserts in the cycle after the start strobe.
- R2: After synchronous reset all `cs_n` lines are high, `sel_err`, `data_phase`, `data_done` and `read_dir` are low, and `lane_en` is 4'b0001.
- R3: A command with `lock_cs`=0 and `release_cs`=0, issued while no line is held, keeps its line low until the done strobe and releases it in the cycle after done.
- R4: A command with `lock_cs`=1 and `release_cs`=0 keeps its line low after its done strobe.
- R5: A held line stays low without a break through later commands to the same target whose `release_cs` is 0, whatever their `lock_cs`. It goes high in the cycle after the done strobe of the first command with `release_cs`=1.
- R6: A command with `release_cs`=1 releases its line in the cycle after its done strobe, even when `lock_cs` is 1.
- R7: Select code 2'b11 is reserved. It asserts no line, drops any held line, and raises `sel_err` for exactly one cycle, in the cycle after the start strobe.
- R8: When a command names a different target while a line is held, all lines are high for at least one cycle before the new line goes low.
- R9: With `xfer_en`=1 and `xfer_bytes`=N>0, `data_phase` is high from the cycle after start. In the cycle after the N-th `byte_tick`, `data_done` is high for one cycle and `data_phase` falls.
- R10: With `xfer_en`=0 no data phase occurs: `byte_tick` strobes leave `data_phase` and `data_done` low.
- R11: `read_dir` is high only when the latched command had both `xfer_en` and `read_en` set.
- R12: `lane_en` decodes the latched `lane_code`: 0 gives 4'b0001 (one lane), 1 gives 4'b0011 (two lanes), 2 gives 4'b1111 (four lanes), and 3 is treated as one lane.
- R13: A done strobe while no command is active changes no chip-select line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_start | input | 1 | One-cycle strobe that begins a command and latches the control inputs |
| tgt_sel | input | 2 | Target select code |
| lock_cs | input | 1 | Keep the line asserted after this command |
| release_cs | input | 1 | Release the line when this command ends |
| xfer_en | input | 1 | Command has a data phase |
| read_en | input | 1 | Data phase reads from the device |
| lane_code | input | 2 | Data lane width code |
| xfer_bytes | input | CNT_W | Bytes in the data phase |
| byte_tick | input | 1 | One byte moved by the shift engine |
| cmd_done | input | 1 | Command finished strobe from the shift engine |
| cs_n | output | 3 | Active-low chip selects |
| lane_en | output | 4 | Enabled data lanes, bit per lane |
| read_dir | output | 1 | Current data direction is read |
| data_phase | output | 1 | Data phase in progress |
| data_done | output | 1 | One-cycle pulse when the byte count is reached |
| sel_err | output | 1 | One-cycle pulse for a reserved select code |

## Verification
A wrong hold flag shows at the ports in the cycle after a done strobe. In that cycle the held line either releases early or stays low when it should not. A wrong stored target shows as two lines low at once, or as a switch between devices with no idle gap, in the first cycle after the next start. A counter that is off by one moves the `data_done` pulse one tick early or late, and this is seen in the cycle after the final byte tick.

// File: rtl/spi_cs_pkg.sv
// Package: shared types and decode helpers for the chip-select controller.
// Assumes a fixed set of three select lines and up to four data lanes.
package spi_cs_pkg;

    localparam int NUM_CS   = 3;
    localparam int SEL_W    = 2;
    localparam int LANE_MAX = 4;

    // Control word captured at command start
    typedef struct packed {
        logic             lock;
        logic             rel;
        logic             xfer;
        logic             rd;
        logic [1:0]       lane;
    } cmd_word_t;

    // Lane code to per-lane enable mask; reserved code falls back to one lane
    function automatic logic [LANE_MAX-1:0] lane_mask(input logic [1:0] code);
        logic [LANE_MAX-1:0] m;
        case (code)
            2'd1:    m = 4'b0011;
            2'd2:    m = 4'b1111;
            default: m = 4'b0001;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/cs_target_decode.sv
// Module: cs_target_decode
// Turns the select code into a one-hot target vector and a valid flag.
// Codes at or above NCS are reserved and yield an all-zero vector.
module cs_target_decode #(
    parameter int SEL_W = 2,
    parameter int NCS   = 3
) (
    input  logic [SEL_W-1:0] sel,
    output logic [NCS-1:0]   tgt_oh,
    output logic             sel_valid
);

    // One comparator per select line
    for (genvar i = 0; i < NCS; i++) begin : g_line
        assign tgt_oh[i] = (sel == SEL_W'(i));
    end

    // A code is valid when it names an existing line
    assign sel_valid = |tgt_oh;

endmodule

// File: rtl/cs_hold_fsm.sv
// Module: cs_hold_fsm
// Tracks the active command, the sticky lock and the asserted target.
// Drives the active-low select lines from registers and inserts an idle
// cycle when the target changes under a held lock.
// Assumes start and done never arrive in the same cycle and that a
// start does not arrive while a command is still active.
module cs_hold_fsm #(
    parameter int NCS = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic           sel_valid,
    input  logic [NCS-1:0] tgt_oh,
    input  logic           lock,
    input  logic           rel,
    input  logic           done,
    output logic [NCS-1:0] cs_n,
    output logic           sel_err
);

    logic           active_q;
    logic           held_q;
    logic           cs_on_q;
    logic           gap_q;
    logic           lock_q;
    logic           rel_q;
    logic           valid_q;
    logic [NCS-1:0] tgt_q;
    logic           keep;

    // Line stays asserted past done when locked or held, unless released
    assign keep = (lock_q | held_q) & ~rel_q & valid_q;

    // Command and hold state update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            held_q   <= 1'b0;
            cs_on_q  <= 1'b0;
            gap_q    <= 1'b0;
            lock_q   <= 1'b0;
            rel_q    <= 1'b0;
            valid_q  <= 1'b0;
            tgt_q    <= '0;
            sel_err  <= 1'b0;
        end else begin
            sel_err <= 1'b0;
            if (start) begin
                active_q <= 1'b1;
                lock_q   <= lock;
                rel_q    <= rel;
                valid_q  <= sel_valid;
                if (!sel_valid) begin
                    cs_on_q <= 1'b0;
                    held_q  <= 1'b0;
                    gap_q   <= 1'b0;
                    sel_err <= 1'b1;
                end else if (cs_on_q && (tgt_q != tgt_oh)) begin
                    tgt_q   <= tgt_oh;
                    cs_on_q <= 1'b0;
                    gap_q   <= 1'b1;
                end else begin
                    tgt_q   <= tgt_oh;
                    cs_on_q <= 1'b1;
                end
            end else if (done && active_q) begin
                active_q <= 1'b0;
                gap_q    <= 1'b0;
                cs_on_q  <= keep;
                held_q   <= keep;
            end else if (gap_q) begin
                gap_q   <= 1'b0;
                cs_on_q <= 1'b1;
            end
        end
    end

    // Active-low outputs from the stored target
    assign cs_n = ~(tgt_q & {NCS{cs_on_q}});

endmodule

// File: rtl/xfer_byte_counter.sv
// Module: xfer_byte_counter
// Counts down the bytes of a data phase and pulses once at the last one.
// A load with a zero count starts no data phase.
module xfer_byte_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] count,
    input  logic             tick,
    output logic             busy,
    output logic             done_pulse
);

    logic [CNT_W-1:0] left_q;

    // Remaining-byte counter with completion pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_q     <= '0;
            busy       <= 1'b0;
            done_pulse <= 1'b0;
        end else begin
            done_pulse <= 1'b0;
            if (load) begin
                left_q <= count;
                busy   <= (count != '0);
            end else if (busy && tick) begin
                left_q <= left_q - 1'b1;
                if (left_q == CNT_W'(1)) begin
                    busy       <= 1'b0;
                    done_pulse <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/spi_cs_ctrl.sv
// Module: spi_cs_ctrl
// Chip-select controller for a serial master: latches a per-command
// control word, drives three active-low selects with sticky locking and
// counts the data phase. The shift engine supplies start, done and byte
// strobes; it must not start a command while one is still active.
module spi_cs_ctrl
    import spi_cs_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmd_start,
    input  logic [SEL_W-1:0]    tgt_sel,
    input  logic                lock_cs,
    input  logic                release_cs,
    input  logic                xfer_en,
    input  logic                read_en,
    input  logic [1:0]          lane_code,
    input  logic [CNT_W-1:0]    xfer_bytes,
    input  logic                byte_tick,
    input  logic                cmd_done,
    output logic [NUM_CS-1:0]   cs_n,
    output logic [LANE_MAX-1:0] lane_en,
    output logic                read_dir,
    output logic                data_phase,
    output logic                data_done,
    output logic                sel_err
);

    logic [NUM_CS-1:0] tgt_oh;
    logic              sel_valid;
    cmd_word_t         word;

    // Gather the control inputs into one word
    assign word = '{lock: lock_cs, rel: release_cs, xfer: xfer_en,
                    rd: read_en, lane: lane_code};

    cs_target_decode #(.SEL_W(SEL_W), .NCS(NUM_CS)) u_dec (
        .sel       (tgt_sel),
        .tgt_oh    (tgt_oh),
        .sel_valid (sel_valid)
    );

    cs_hold_fsm #(.NCS(NUM_CS)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (cmd_start),
        .sel_valid (sel_valid),
        .tgt_oh    (tgt_oh),
        .lock      (word.lock),
        .rel       (word.rel),
        .done      (cmd_done),
        .cs_n      (cs_n),
        .sel_err   (sel_err)
    );

    xfer_byte_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (cmd_start & word.xfer),
        .count      (xfer_bytes),
        .tick       (byte_tick),
        .busy       (data_phase),
        .done_pulse (data_done)
    );

    // Latch direction and lane width for the command
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lane_en  <= lane_mask(2'd0);
            read_dir <= 1'b0;
        end else if (cmd_start) begin
            lane_en  <= lane_mask(word.lane);
            read_dir <= word.xfer & word.rd;
        end
    end

endmodule

// File: rtl/spi_cs_ctrl_chk.sv
// Module: spi_cs_ctrl_chk
// Port-level properties of the chip-select controller, bound to the top.
module spi_cs_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] cs_n,
    input logic       sel_err,
    input logic       data_phase,
    input logic       data_done
);

    // R1: never more than one select asserted
    p_cs_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n));

    // R2: first cycle out of reset has every select idle
    p_reset_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (cs_n == 3'b111 && !data_phase));

    // R7: a reserved-code error never coincides with an asserted select
    p_err_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sel_err |-> (cs_n == 3'b111));

    // R7: the error flag lasts one cycle
    p_err_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sel_err |=> !sel_err);

    // R8: a newly asserted select is preceded by an all-idle cycle
    p_break_make_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n != 3'b111 && cs_n != $past(cs_n)) |-> ($past(cs_n) == 3'b111));

    // R9: completion is a single pulse and ends the data phase
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        data_done |=> !data_done);
    p_done_phase_r9: assert property (@(posedge clk) disable iff (!rst_n)
        data_done |-> !data_phase);

endmodule

bind spi_cs_ctrl spi_cs_ctrl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_n       (cs_n),
    .sel_err    (sel_err),
    .data_phase (data_phase),
    .data_done  (data_done)
);

// File: tb/spi_cs_ctrl_test.sv
`timescale 1ns/1ps
module spi_cs_ctrl_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_start = 1'b0;
    logic [1:0] tgt_sel = 2'b00;
    logic       lock_cs = 1'b0;
    logic       release_cs = 1'b0;
    logic       xfer_en = 1'b0;
    logic       read_en = 1'b0;
    logic [1:0] lane_code = 2'b00;
    logic [7:0] xfer_bytes = 8'd0;
    logic       byte_tick = 1'b0;
    logic       cmd_done = 1'b0;
    logic [2:0] cs_n;
    logic [3:0] lane_en;
    logic       read_dir;
    logic       data_phase;
    logic       data_done;
    logic       sel_err;

    int tests = 0;
    int fails = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    spi_cs_ctrl uut (
        .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .tgt_sel(tgt_sel),
        .lock_cs(lock_cs), .release_cs(release_cs), .xfer_en(xfer_en),
        .read_en(read_en), .lane_code(lane_code), .xfer_bytes(xfer_bytes),
        .byte_tick(byte_tick), .cmd_done(cmd_done), .cs_n(cs_n),
        .lane_en(lane_en), .read_dir(read_dir), .data_phase(data_phase),
        .data_done(data_done), .sel_err(sel_err)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic chk_cs(input string req, input logic [2:0] exp);
        check(cs_n == exp, req, cs_n, exp);
    endtask

    // Issue a start pulse; returns at the negedge after the latching edge
    task automatic cmd(input logic [1:0] sel, input logic lk, input logic rl,
                       input logic xf, input logic rd, input logic [1:0] ln,
                       input logic [7:0] nb);
        @(negedge clk);
        tgt_sel = sel; lock_cs = lk; release_cs = rl; xfer_en = xf;
        read_en = rd; lane_code = ln; xfer_bytes = nb; cmd_start = 1'b1;
        @(negedge clk);
        cmd_start = 1'b0;
    endtask

    task automatic done();
        @(negedge clk); cmd_done = 1'b1;
        @(negedge clk); cmd_done = 1'b0;
    endtask

    task automatic tick();
        @(negedge clk); byte_tick = 1'b1;
        @(negedge clk); byte_tick = 1'b0;
    endtask

    task automatic t_reset();
        chk_cs("R2 cs idle", 3'b111);
        check(!sel_err && !data_phase && !data_done && !read_dir, "R2 flags", 0, 0);
        check(lane_en == 4'b0001, "R2 lanes", lane_en, 1);
    endtask

    task automatic t_decode();
        cmd(2'b00, 0, 0, 0, 0, 0, 0); chk_cs("R1 sel0", 3'b110);
        done(); chk_cs("R3 release after done", 3'b111);
        cmd(2'b01, 0, 0, 0, 0, 0, 0); chk_cs("R1 sel1", 3'b101);
        done();
        cmd(2'b10, 0, 0, 0, 0, 0, 0); chk_cs("R1 sel2", 3'b011);
        @(negedge clk); chk_cs("R3 held mid command", 3'b011);
        done(); chk_cs("R3 release sel2", 3'b111);
    endtask

    task automatic t_lock();
        cmd(2'b01, 1, 0, 0, 0, 0, 0); done();
        chk_cs("R4 lock holds after done", 3'b101);
        cmd(2'b01, 0, 0, 0, 0, 0, 0); chk_cs("R5 same target no gap", 3'b101);
        done(); chk_cs("R5 still held", 3'b101);
        cmd(2'b01, 0, 1, 0, 0, 0, 0); chk_cs("R5 held in release cmd", 3'b101);
        done(); chk_cs("R5 release at done", 3'b111);
        cmd(2'b00, 1, 1, 0, 0, 0, 0); done();
        chk_cs("R6 release beats lock", 3'b111);
    endtask

    task automatic t_idle_done();
        done(); chk_cs("R13 stray done idle", 3'b111);
        cmd(2'b10, 1, 0, 0, 0, 0, 0); done();
        done(); chk_cs("R13 stray done keeps hold", 3'b011);
    endtask

    task automatic t_switch();
        cmd(2'b00, 0, 0, 0, 0, 0, 0);
        chk_cs("R8 gap cycle", 3'b111);
        @(negedge clk); chk_cs("R8 new target", 3'b110);
        done(); chk_cs("R5 hold moved to new target", 3'b110);
        cmd(2'b00, 0, 1, 0, 0, 0, 0); done();
        chk_cs("R5 released", 3'b111);
    endtask

    task automatic t_reserved();
        cmd(2'b01, 1, 0, 0, 0, 0, 0); done();
        cmd(2'b11, 0, 0, 0, 0, 0, 0);
        chk_cs("R7 no select", 3'b111);
        check(sel_err, "R7 err raised", sel_err, 1);
        @(negedge clk);
        check(!sel_err, "R7 err one cycle", sel_err, 0);
        done(); chk_cs("R7 hold dropped", 3'b111);
    endtask

    task automatic t_xfer();
        cmd(2'b00, 0, 0, 1, 1, 2'd2, 8'd3);
        check(data_phase, "R9 phase up", data_phase, 1);
        check(read_dir, "R11 read", read_dir, 1);
        check(lane_en == 4'b1111, "R12 four lanes", lane_en, 4'hf);
        tick(); tick();
        check(!data_done && data_phase, "R9 not yet done", data_done, 0);
        tick();
        check(data_done, "R9 done pulse", data_done, 1);
        check(!data_phase, "R9 phase down", data_phase, 0);
        @(negedge clk);
        check(!data_done, "R9 pulse one cycle", data_done, 0);
        done();
        cmd(2'b00, 0, 0, 1, 0, 2'd1, 8'd1);
        check(!read_dir, "R11 write", read_dir, 0);
        check(lane_en == 4'b0011, "R12 two lanes", lane_en, 3);
        tick(); check(data_done, "R9 single byte", data_done, 1);
        done();
    endtask

    task automatic t_noxfer();
        cmd(2'b10, 0, 0, 0, 1, 2'd3, 8'd2);
        check(!data_phase, "R10 no phase", data_phase, 0);
        check(!read_dir, "R11 read without xfer", read_dir, 0);
        check(lane_en == 4'b0001, "R12 code 3 one lane", lane_en, 1);
        for (int i = 0; i < 4; i++) begin
            tick();
            check(!data_done && !data_phase, "R10 tick ignored", data_done, 0);
        end
        done();
        cmd(2'b10, 0, 0, 0, 0, 2'd0, 8'd0);
        check(lane_en == 4'b0001, "R12 one lane", lane_en, 1);
        done();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_decode();
        t_lock();
        t_idle_done();
        t_switch();
        t_reserved();
        t_xfer();
        t_noxfer();
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule